// File: doc/BRIEF.md
# Double-Buffered Serial Transmit Channel

This block is the transmit half of an asynchronous serial port. A processor writes bytes into a one-entry holding register. The block moves each byte into a shift register and sends it on a single serial line as a frame. A frame is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. Because there are two registers, the processor can load the next byte while the current one is still shifting. Frames then follow each other with no idle time between them.

Bit timing comes from a single-cycle bit-time enable (`bit_tick`), which an external baud source provides. The serial output changes only in response to that enable. Frame shape is set by the mode inputs, which are sampled when a byte moves from the holding register into the shift register. The block reports two flags. `tx_ready` means the holding register can accept a byte. `tx_empty` means both registers are empty and the line is at mark.

Enable and disable commands gate the channel. A disable lets the frame already on the line finish. A byte still in the holding register stays there and waits for the next enable.

Top module: `sertx_chan`

## Requirements
- R1: After synchronous reset, `txd` is 1, `tx_empty` is 1, `tx_ready` is 0, and the channel is disabled.
- R2: A frame is a start bit of 0, then the data bits least significant first, then the optional parity bit, then the stop bits of 1. The data-bit count is 5 + `mode_dbits` (code 0 gives 5 bits, code 3 gives 8 bits).
- R3: `mode_par` selects the parity bit. Code 0 is even, code 1 is odd, code 2 is a constant 0, code 3 is a constant 1, and codes 4 to 7 send no parity bit. Even and odd parity are computed over the selected data bits only.
- R4: `mode_stop2` = 0 sends one stop bit and `mode_stop2` = 1 sends two.
- R5: `txd` changes only on the clock edge at which `bit_tick` is 1, so each bit lasts exactly one bit-time interval.
- R6: `tx_ready` is 1 exactly when the channel is enabled and the holding register is empty. A write with `tx_ready` = 1 captures `wr_data`. A write while `tx_ready` = 0 has no effect.
- R7: While a frame is shifting, a byte waiting in the holding register starts its start bit at the `bit_tick` edge that ends the last stop bit, with no idle bit between the frames. `tx_ready` returns to 1 once that byte has moved into the shift register.
- R8: When the holding register is empty and the last stop bit has ended, `txd` stays at 1 and `tx_empty` is 1. An accepted write clears `tx_empty` on the next cycle.
- R9: No frame starts unless the channel is enabled by `cmd_enable`. After `cmd_disable`, the frame in progress finishes, a byte in the holding register is not sent until the channel is enabled again, and `tx_ready` stays 0. If both commands are asserted in the same cycle, disable wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle bit-time enable |
| cmd_enable | input | 1 | Enable command pulse |
| cmd_disable | input | 1 | Disable command pulse |
| wr_en | input | 1 | Holding-register write strobe |
| wr_data | input | 8 | Byte to send |
| mode_dbits | input | 2 | Data-bit count minus 5 |
| mode_par | input | 3 | Parity select code |
| mode_stop2 | input | 1 | 1 selects two stop bits |
| txd | output | 1 | Serial output, idle high |
| tx_ready | output | 1 | Holding register can accept a byte |
| tx_empty | output | 1 | Both registers empty, line at mark |

## Verification
The hardest situation to reach is a disable command that arrives while one character is on the line and a second character is waiting in the holding register. The stimulus waits until the serial output shows a start bit, writes the second byte, and then pulses disable. It holds back the expected entry for that byte until after a later re-enable, so any early transmission shows up as an unexpected frame. A second hard case is the zero-gap handover between frames. The scoreboard checks it by counting the idle bit times before each frame that is marked as chained.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
    localparam int TX_DATA_W  = 8;
    localparam int TX_MIN_DB  = TX_DATA_W - 3;
    localparam int TX_FRAME_W = TX_DATA_W + 4;
    localparam int TX_CNT_W   = $clog2(TX_FRAME_W + 1);

    typedef enum logic [2:0] {
        PAR_EVEN = 3'd0,
        PAR_ODD  = 3'd1,
        PAR_ZERO = 3'd2,
        PAR_ONE  = 3'd3,
        PAR_NONE = 3'd4
    } par_e;

    typedef struct packed {
        logic [1:0] dbits;
        par_e       par;
        logic       stop2;
    } tx_mode_t;

    typedef struct packed {
        logic [TX_FRAME_W-1:0] bits;
        logic [TX_CNT_W-1:0]   len;
    } tx_frame_t;

    function automatic logic par_has(input par_e p);
        return (p == PAR_EVEN) || (p == PAR_ODD) || (p == PAR_ZERO) || (p == PAR_ONE);
    endfunction

    function automatic logic par_value(input logic [TX_DATA_W-1:0] dm, input par_e p);
        case (p)
            PAR_EVEN: return ^dm;
            PAR_ODD:  return ~^dm;
            PAR_ONE:  return 1'b1;
            default:  return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/sertx_framer.sv
module sertx_framer
    import sertx_pkg::*;
(
    input  logic [TX_DATA_W-1:0] data,
    input  tx_mode_t             mode,
    output tx_frame_t            frame
);
    logic [TX_CNT_W-1:0]  nd;
    logic [TX_CNT_W-1:0]  pidx;
    logic [TX_DATA_W-1:0] dmask;
    logic                 has_p;

    assign nd    = TX_CNT_W'(TX_MIN_DB) + TX_CNT_W'(mode.dbits);
    assign pidx  = nd + TX_CNT_W'(1);
    assign has_p = par_has(mode.par);

    always_comb begin
        dmask = '0;
        for (int i = 0; i < TX_DATA_W; i++) begin
            if (i < int'(nd)) dmask[i] = data[i];
        end
        frame.bits    = '1;
        frame.bits[0] = 1'b0;
        for (int i = 0; i < TX_DATA_W; i++) begin
            if (i < int'(nd)) frame.bits[1+i] = dmask[i];
        end
        if (has_p) frame.bits[pidx] = par_value(dmask, mode.par);
        frame.len = TX_CNT_W'(2) + nd + TX_CNT_W'(has_p) + TX_CNT_W'(mode.stop2);
    end
endmodule

// File: rtl/sertx_hold.sv
module sertx_hold
    import sertx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 wr_en,
    input  logic [TX_DATA_W-1:0] wr_data,
    input  logic                 take,
    output logic [TX_DATA_W-1:0] hold_q,
    output logic                 full,
    output logic                 ready
);
    assign ready = en && !full;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            full   <= 1'b0;
        end else if (take) begin
            full   <= 1'b0;
        end else if (wr_en && ready) begin
            hold_q <= wr_data;
            full   <= 1'b1;
        end
    end

    // R6
    ignored_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !ready && !take) |=> ($stable(hold_q) && $stable(full)));

    // R6
    accept_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ready) |=> (full && hold_q == $past(wr_data)));
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
    import sertx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      bit_tick,
    input  logic      go_ok,
    input  tx_frame_t frame,
    output logic      txd,
    output logic      busy,
    output logic      take
);
    logic [TX_FRAME_W-1:0] sh;
    logic [TX_CNT_W-1:0]   cnt;
    logic                  slot_free;

    assign slot_free = !busy || (cnt == '0);
    assign take      = bit_tick && slot_free && go_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            txd  <= 1'b1;
            busy <= 1'b0;
            sh   <= '0;
            cnt  <= '0;
        end else if (bit_tick) begin
            if (slot_free) begin
                if (go_ok) begin
                    txd  <= frame.bits[0];
                    sh   <= frame.bits >> 1;
                    cnt  <= frame.len - TX_CNT_W'(1);
                    busy <= 1'b1;
                end else begin
                    txd  <= 1'b1;
                    busy <= 1'b0;
                end
            end else begin
                txd <= sh[0];
                sh  <= sh >> 1;
                cnt <= cnt - TX_CNT_W'(1);
            end
        end
    end

    // R2
    start_bit_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> (!txd && busy));

    // R5
    txd_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_tick |=> $stable(txd));

    // R8
    idle_mark_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> txd);
endmodule

// File: rtl/sertx_chan.sv
module sertx_chan
    import sertx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bit_tick,
    input  logic                 cmd_enable,
    input  logic                 cmd_disable,
    input  logic                 wr_en,
    input  logic [TX_DATA_W-1:0] wr_data,
    input  logic [1:0]           mode_dbits,
    input  logic [2:0]           mode_par,
    input  logic                 mode_stop2,
    output logic                 txd,
    output logic                 tx_ready,
    output logic                 tx_empty
);
    logic                 en_q;
    logic                 full;
    logic                 busy;
    logic                 take;
    logic [TX_DATA_W-1:0] hold_q;
    tx_mode_t             mode;
    tx_frame_t            frame;

    assign mode.dbits = mode_dbits;
    assign mode.par   = par_e'(mode_par);
    assign mode.stop2 = mode_stop2;

    always_ff @(posedge clk) begin
        if (rst)              en_q <= 1'b0;
        else if (cmd_disable) en_q <= 1'b0;
        else if (cmd_enable)  en_q <= 1'b1;
    end

    sertx_hold hold_i (
        .clk(clk), .rst(rst), .en(en_q), .wr_en(wr_en), .wr_data(wr_data),
        .take(take), .hold_q(hold_q), .full(full), .ready(tx_ready)
    );

    sertx_framer framer_i (
        .data(hold_q), .mode(mode), .frame(frame)
    );

    sertx_shift shift_i (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .go_ok(full && en_q),
        .frame(frame), .txd(txd), .busy(busy), .take(take)
    );

    assign tx_empty = !full && !busy;

    // R9
    ready_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> en_q);

    // R9
    off_stays_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_q && !busy) |=> !busy);

    // R8
    empty_mark_chk: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> txd);
endmodule

// File: tb/sertx_chan_tb_top.sv
`timescale 1ns/1ps
module sertx_chan_tb_top;
    localparam int TICK_DIV = 4;

    typedef struct {
        logic [11:0] bits;
        int          len;
        bit          follow;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_tick = 1'b0;
    logic       cmd_enable = 1'b0;
    logic       cmd_disable = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] mode_dbits = '0;
    logic [2:0] mode_par = '0;
    logic       mode_stop2 = 1'b0;
    logic       txd, tx_ready, tx_empty;

    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    exp_t q[$];
    exp_t cur;
    bit   in_fr = 0;
    int   idx = 0;
    int   idle_cnt = 0;
    int   tcnt = 0;
    logic last_txd = 1'b1;

    always #10 clk = ~clk;

    sertx_chan dut_i (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .cmd_enable(cmd_enable),
        .cmd_disable(cmd_disable), .wr_en(wr_en), .wr_data(wr_data),
        .mode_dbits(mode_dbits), .mode_par(mode_par), .mode_stop2(mode_stop2),
        .txd(txd), .tx_ready(tx_ready), .tx_empty(tx_empty)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic exp_t mk(input logic [7:0] d, input int db, input int par,
                                input bit s2, input bit fol);
        exp_t e;
        int n = db + 5;
        int ones = 0;
        int k;
        e.bits = '1;
        e.bits[0] = 1'b0;
        for (int i = 0; i < n; i++) begin
            e.bits[1+i] = d[i];
            if (d[i]) ones++;
        end
        k = 1 + n;
        if (par < 4) begin
            case (par)
                0: e.bits[k] = (ones % 2) == 1;
                1: e.bits[k] = (ones % 2) == 0;
                2: e.bits[k] = 1'b0;
                default: e.bits[k] = 1'b1;
            endcase
            k++;
        end
        e.len = k + 1 + (s2 ? 1 : 0);
        e.follow = fol;
        return e;
    endfunction

    // Monitor and bit-time source: one process so tick sampling has no race.
    always @(negedge clk) begin
        if (rst) begin
            in_fr = 0;
            idle_cnt = 0;
        end else if (bit_tick) begin
            if (!in_fr) begin
                if (txd == 1'b0) begin
                    if (q.size() == 0) begin
                        chk(0, "R9/R6 unexpected frame", 1, 0);
                    end else begin
                        cur = q.pop_front();
                        in_fr = 1;
                        idx = 1;
                        chk(cur.bits[0] == txd, "R2 start bit", int'(txd), 0);
                        if (cur.follow) chk(idle_cnt == 0, "R7 gap between frames", idle_cnt, 0);
                    end
                end else begin
                    idle_cnt++;
                end
            end else begin
                chk(txd == cur.bits[idx], "R2/R3/R4 frame bit", int'(txd), int'(cur.bits[idx]));
                idx++;
                if (idx == cur.len) begin
                    in_fr = 0;
                    idle_cnt = 0;
                end
            end
        end else begin
            chk(txd == last_txd, "R5 change off tick", int'(txd), int'(last_txd));
        end
        last_txd = txd;
        tcnt = (tcnt + 1) % TICK_DIV;
        bit_tick <= (tcnt == 0);
    end

    task automatic send(input logic [7:0] d, input int db, input int par,
                        input bit s2, input bit fol, input bit push);
        while (!tx_ready) @(negedge clk);
        mode_dbits = 2'(db);
        mode_par   = 3'(par);
        mode_stop2 = s2;
        wr_data    = d;
        wr_en      = 1'b1;
        if (push) q.push_back(mk(d, db, par, s2, fol));
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        while (q.size() != 0 || in_fr || !tx_empty) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_enable();
        cmd_enable = 1'b1;
        @(negedge clk);
        cmd_enable = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(txd == 1'b1, "R1 txd", int'(txd), 1);
        chk(tx_empty == 1'b1, "R1 tx_empty", int'(tx_empty), 1);
        chk(tx_ready == 1'b0, "R1 tx_ready", int'(tx_ready), 0);

        // R9: write while disabled is ignored (monitor flags any frame)
        wr_data = 8'hA5;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (40) @(negedge clk);
        chk(tx_empty == 1'b1, "R9 disabled write kept empty", int'(tx_empty), 1);
        chk(txd == 1'b1, "R9 disabled line idle", int'(txd), 1);

        pulse_enable();
        chk(tx_ready == 1'b1, "R6 ready after enable", int'(tx_ready), 1);

        // R2 R3 R4: every data count, parity code and stop count
        for (int db = 0; db < 4; db++) begin
            for (int pi = 0; pi < 6; pi++) begin
                for (int s = 0; s < 2; s++) begin
                    int par = (pi == 5) ? 7 : pi;
                    send(8'(8'h5A ^ (db * 37 + pi * 11 + s * 101)), db, par, s[0], 1'b0, 1'b1);
                end
            end
        end
        wait_idle();
        chk(tx_empty == 1'b1, "R8 empty after last frame", int'(tx_empty), 1);
        chk(txd == 1'b1, "R8 mark when empty", int'(txd), 1);

        // R7: chained frames, R6 ignored write while holding full
        send(8'h3C, 3, 0, 1'b0, 1'b0, 1'b1);
        chk(tx_empty == 1'b0, "R8 write clears empty", int'(tx_empty), 0);
        send(8'hC3, 2, 1, 1'b1, 1'b1, 1'b1);
        chk(tx_ready == 1'b0, "R6 ready low while holding full", int'(tx_ready), 0);
        wr_data = 8'hFF;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        send(8'h81, 1, 3, 1'b0, 1'b1, 1'b1);
        chk(tx_ready == 1'b0, "R7 ready low until transfer", int'(tx_ready), 0);
        wait_idle();

        // R9: disable with a frame shifting and a byte waiting
        send(8'h96, 3, 4, 1'b0, 1'b0, 1'b1);
        while (txd != 1'b0) @(negedge clk);
        send(8'h69, 3, 0, 1'b1, 1'b0, 1'b0);
        cmd_disable = 1'b1;
        @(negedge clk);
        cmd_disable = 1'b0;
        chk(tx_ready == 1'b0, "R9 ready low when disabled", int'(tx_ready), 0);
        repeat (20 * TICK_DIV) @(negedge clk);
        chk(txd == 1'b1, "R9 line idle after disable", int'(txd), 1);
        chk(tx_empty == 1'b0, "R9 waiting byte kept", int'(tx_empty), 0);
        chk(tx_ready == 1'b0, "R9 ready stays low", int'(tx_ready), 0);
        q.push_back(mk(8'h69, 3, 0, 1'b1, 1'b0));
        pulse_enable();
        wait_idle();
        chk(tx_empty == 1'b1, "R8 empty at end", int'(tx_empty), 1);
        chk(tx_ready == 1'b1, "R6 ready at end", int'(tx_ready), 1);
        chk(q.size() == 0, "R2 all frames seen", q.size(), 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule